// File: doc/BRIEF.md
# Power Mode Control Register Unit

This block holds the power-control special function register of an 8051-style core. The register has one fixed SFR address. It decides when the core stops fetching instructions, and it drives a halt line to the instruction sequencer. Software asks for a low-power state by setting one of two request bits in the register. The request takes effect only when the instruction that wrote the bit completes. From that point the halt line stays high until a wake event.

There are two low-power states. The clock keeps running in both of them.
- Idle ends when an enabled interrupt arrives. Hardware then clears the idle request bit, so the core can service the interrupt and return to the instruction after the one that slept.
- Stop ignores interrupts. Only a watchdog reset ends it.

The watchdog reset returns every register bit to zero, and the core restarts from its reset vector. The register also stores two general-purpose flags and the serial baud-doubler enable, and the doubler has its own output wire.

The controller has four states:
- PM_RUN: normal execution.
- PM_ARMED: a request bit is set, but the current instruction has not yet completed.
- PM_IDLE: halted, and an interrupt wakes the core.
- PM_STOP: halted, and only the watchdog wakes the core.

The transitions are:
- RUN/ARMED → IDLE or STOP on `instr_done` while a request is set. The request may be written in that same cycle.
- RUN → ARMED when a request is written without `instr_done`.
- ARMED → RUN when software clears the request before `instr_done`.
- IDLE → RUN on `irq_wake`.
- Any state → RUN on `wdog_rst`.

Top module: `pwr_mode_ctl`

## Requirements
- R1: After reset, `halt` is 0, `baud_dbl` and `gp_flag` are 0, and a read at address 0x87 returns 0x00.
- R2: A write to address 0x87 stores bit 7 (baud doubler), bit 3 (flag 1) and bit 2 (flag 0). These bits read back in place, and `baud_dbl` and `gp_flag[1:0]` (bit 3 to gp_flag[1], bit 2 to gp_flag[0]) follow them. A write to any other address changes nothing, and a read at any other address returns 0x00.
- R3: Bits 6 to 4 always read as 0. Writing 1 to them has no effect.
- R4: Writing 1 to bit 0 (idle request) without `instr_done` leaves `halt` at 0. `halt` rises on the cycle after the next `instr_done` strobe.
- R5: When the write that sets a request bit and `instr_done` come in the same cycle, `halt` is 1 on the next cycle.
- R6: In idle, `irq_wake` drops `halt` on the next cycle and clears bit 0. All other bits keep their values.
- R7: In stop (bit 1), `irq_wake` has no effect: `halt` stays 1 and bit 1 stays set.
- R8: If bits 1 and 0 are both set when the instruction completes, stop behaviour applies, and `irq_wake` does not drop `halt`.
- R9: `wdog_rst` clears all register bits and `halt` on the next cycle from any state. It overrides an `irq_wake` in the same cycle.
- R10: Register writes are ignored while `halt` is 1.
- R11: Clearing both request bits before `instr_done` cancels the request, and `halt` stays 0 after the strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock, running in all modes |
| rst_n | input | 1 | Asynchronous active-low reset |
| wdog_rst | input | 1 | Watchdog reset pulse, synchronous clear |
| sfr_addr | input | 8 | SFR address for read and write |
| sfr_wr | input | 1 | SFR write strobe |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | Read data; the register when the address matches, else 0 |
| instr_done | input | 1 | One-cycle strobe marking instruction completion |
| irq_wake | input | 1 | An enabled interrupt is requesting service |
| halt | output | 1 | Suspends the instruction sequencer |
| baud_dbl | output | 1 | Serial baud-rate doubler enable |
| gp_flag | output | 2 | General-purpose flags 1 and 0 |

## Verification
Two groups of events can fall on the same clock edge.
- The write that sets a request bit can coincide with the `instr_done` strobe. The bench drives both in one cycle and expects `halt` high right after that edge, with no armed wait.
- A wake interrupt can coincide with a watchdog reset while the core is idle. The bench raises `irq_wake` and `wdog_rst` in the same cycle and then checks the whole register. If the interrupt path won, bit 7 or the flags would survive; the expected result is that every bit reads zero and `halt` is low.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
    localparam int REG_W = 8;

    // Bit positions software relies on
    localparam int POS_BAUD = 7;
    localparam int POS_GF1  = 3;
    localparam int POS_GF0  = 2;
    localparam int POS_STOP = 1;
    localparam int POS_IDLE = 0;

    typedef enum logic [1:0] {
        PM_RUN   = 2'd0,
        PM_ARMED = 2'd1,
        PM_IDLE  = 2'd2,
        PM_STOP  = 2'd3
    } pm_state_t;

    typedef struct packed {
        logic baud;
        logic gf1;
        logic gf0;
        logic stop;
        logic idle;
    } pwr_bits_t;

    function automatic logic [REG_W-1:0] pack_bits(input pwr_bits_t b);
        logic [REG_W-1:0] v;
        v = '0;
        v[POS_BAUD] = b.baud;
        v[POS_GF1]  = b.gf1;
        v[POS_GF0]  = b.gf0;
        v[POS_STOP] = b.stop;
        v[POS_IDLE] = b.idle;
        return v;
    endfunction

    function automatic pwr_bits_t unpack_bits(input logic [REG_W-1:0] v);
        pwr_bits_t b;
        b.baud = v[POS_BAUD];
        b.gf1  = v[POS_GF1];
        b.gf0  = v[POS_GF0];
        b.stop = v[POS_STOP];
        b.idle = v[POS_IDLE];
        return b;
    endfunction
endpackage

// File: rtl/pmc_regfile.sv
module pmc_regfile
    import pmc_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int REG_ADDR = 'h87
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wdog_rst,
    input  logic [ADDR_W-1:0]    sfr_addr,
    input  logic                 sfr_wr,
    input  logic [REG_W-1:0]     sfr_wdata,
    input  logic                 wr_block,
    input  logic                 clr_idle,
    output pwr_bits_t            bits_q,
    output pwr_bits_t            bits_nx,
    output logic [REG_W-1:0]     sfr_rdata
);
    localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_ADDR);

    logic addr_hit;
    logic wr_hit;

    assign addr_hit = (sfr_addr == HIT_ADDR);
    assign wr_hit   = sfr_wr && addr_hit && !wr_block;

    // Value the register takes at the next edge (before wake clearing)
    always_comb begin
        if (wr_hit) bits_nx = unpack_bits(sfr_wdata);
        else        bits_nx = bits_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else if (wdog_rst) begin
            bits_q <= '0;
        end else begin
            bits_q <= bits_nx;
            if (clr_idle) bits_q.idle <= 1'b0;
        end
    end

    assign sfr_rdata = addr_hit ? pack_bits(bits_q) : '0;

    // R9: watchdog pulse leaves every stored bit at zero
    p_wdog_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_rst |=> (bits_q == '0));

    // R10: while halted and not waking, stored bits do not move
    p_frozen_halted_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_block && !clr_idle && !wdog_rst) |=> $stable(bits_q));
endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
    import pmc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wdog_rst,
    input  logic      instr_done,
    input  logic      irq_wake,
    input  logic      req_idle,
    input  logic      req_stop,
    output logic      halt,
    output logic      clr_idle
);
    pm_state_t state_q, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        state_q <= PM_RUN;
        else if (wdog_rst) state_q <= PM_RUN;
        else               state_q <= state_nx;
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            PM_RUN, PM_ARMED: begin
                if (instr_done) begin
                    if (req_stop)      state_nx = PM_STOP;
                    else if (req_idle) state_nx = PM_IDLE;
                    else               state_nx = PM_RUN;
                end else if (req_stop || req_idle) begin
                    state_nx = PM_ARMED;
                end else begin
                    state_nx = PM_RUN;
                end
            end
            PM_IDLE: if (irq_wake) state_nx = PM_RUN;
            PM_STOP: state_nx = PM_STOP;
            default: state_nx = PM_RUN;
        endcase
    end

    always_comb begin
        halt     = 1'b0;
        clr_idle = 1'b0;
        unique case (state_q)
            PM_IDLE: begin
                halt     = 1'b1;
                clr_idle = irq_wake;
            end
            PM_STOP:  halt = 1'b1;
            default:  halt = 1'b0;
        endcase
    end

    // R7: stop is only left through the watchdog
    p_stop_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PM_STOP && !wdog_rst) |=> (state_q == PM_STOP));

    // R6: an interrupt in idle returns to run
    p_idle_wakes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PM_IDLE && irq_wake && !wdog_rst) |=> (state_q == PM_RUN));
endmodule

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl
    import pmc_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int REG_ADDR = 'h87
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wdog_rst,
    input  logic [ADDR_W-1:0] sfr_addr,
    input  logic              sfr_wr,
    input  logic [7:0]        sfr_wdata,
    output logic [7:0]        sfr_rdata,
    input  logic              instr_done,
    input  logic              irq_wake,
    output logic              halt,
    output logic              baud_dbl,
    output logic [1:0]        gp_flag
);
    pwr_bits_t bits_q, bits_nx;
    logic      clr_idle;

    pmc_regfile #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wdog_rst  (wdog_rst),
        .sfr_addr  (sfr_addr),
        .sfr_wr    (sfr_wr),
        .sfr_wdata (sfr_wdata),
        .wr_block  (halt),
        .clr_idle  (clr_idle),
        .bits_q    (bits_q),
        .bits_nx   (bits_nx),
        .sfr_rdata (sfr_rdata)
    );

    pmc_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wdog_rst   (wdog_rst),
        .instr_done (instr_done),
        .irq_wake   (irq_wake),
        .req_idle   (bits_nx.idle),
        .req_stop   (bits_nx.stop),
        .halt       (halt),
        .clr_idle   (clr_idle)
    );

    assign baud_dbl = bits_q.baud;
    assign gp_flag  = {bits_q.gf1, bits_q.gf0};

    // R4: halt only rises right after an instruction completes
    p_halt_needs_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halt) |-> $past(instr_done));

    // R8: with stop set while halted, an interrupt keeps the core halted
    p_stop_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && bits_q.stop && irq_wake && !wdog_rst) |=> halt);
endmodule

// File: tb/sim_pwr_mode_ctl.sv
`timescale 1ns/1ps
module sim_pwr_mode_ctl;
    localparam logic [7:0] A_REG = 8'h87;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wdog_rst = 1'b0;
    logic [7:0] sfr_addr = 8'h00;
    logic       sfr_wr = 1'b0;
    logic [7:0] sfr_wdata = 8'h00;
    logic [7:0] sfr_rdata;
    logic       instr_done = 1'b0;
    logic       irq_wake = 1'b0;
    logic       halt;
    logic       baud_dbl;
    logic [1:0] gp_flag;

    int vecs = 0;
    int bad  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    pwr_mode_ctl u0 (
        .clk(clk), .rst_n(rst_n), .wdog_rst(wdog_rst),
        .sfr_addr(sfr_addr), .sfr_wr(sfr_wr), .sfr_wdata(sfr_wdata),
        .sfr_rdata(sfr_rdata), .instr_done(instr_done), .irq_wake(irq_wake),
        .halt(halt), .baud_dbl(baud_dbl), .gp_flag(gp_flag)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        vecs++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // one clock: inputs set at a falling edge hold over one rising edge
    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        sfr_addr = a;
        #1;
        d = sfr_rdata;
        sfr_addr = A_REG;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic done);
        sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1; instr_done = done;
        cyc();
        sfr_wr = 1'b0; instr_done = 1'b0; sfr_addr = A_REG;
    endtask

    task automatic pulse_done();
        instr_done = 1'b1; cyc(); instr_done = 1'b0;
    endtask

    task automatic pulse_irq();
        irq_wake = 1'b1; cyc(); irq_wake = 1'b0;
    endtask

    task automatic pulse_wdog();
        wdog_rst = 1'b1; cyc(); wdog_rst = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(A_REG, d);
        chk("R1 reg", d, 8'h00);
        chk("R1 halt", {7'd0, halt}, 8'h00);
        chk("R1 outs", {5'd0, baud_dbl, gp_flag}, 8'h00);
    endtask

    task automatic t_regs();
        logic [7:0] d;
        wr(A_REG, 8'hFC, 1'b0);           // bits 7..2 set, reserved included
        rd(A_REG, d);
        chk("R2/R3 readback", d, 8'h8C);
        chk("R2 outs", {5'd0, baud_dbl, gp_flag}, 8'h07);
        chk("R2 no halt", {7'd0, halt}, 8'h00);
        wr(8'h86, 8'h00, 1'b0);           // other address
        rd(A_REG, d);
        chk("R2 other addr write", d, 8'h8C);
        rd(8'h86, d);
        chk("R2 other addr read", d, 8'h00);
        wr(A_REG, 8'h70, 1'b0);           // only reserved bits
        rd(A_REG, d);
        chk("R3 reserved ignored", d, 8'h00);
    endtask

    task automatic t_idle_deferred();
        logic [7:0] d;
        wr(A_REG, 8'h89, 1'b0);           // baud + gf1 + idle
        chk("R4 halt waits", {7'd0, halt}, 8'h00);
        cyc();
        chk("R4 still waits", {7'd0, halt}, 8'h00);
        pulse_done();
        chk("R4 halt after done", {7'd0, halt}, 8'h01);
        wr(A_REG, 8'h00, 1'b0);           // attempt while halted
        rd(A_REG, d);
        chk("R10 write ignored", d, 8'h89);
        pulse_irq();
        chk("R6 halt drops", {7'd0, halt}, 8'h00);
        rd(A_REG, d);
        chk("R6 idle cleared", d, 8'h88);
    endtask

    task automatic t_same_cycle();
        logic [7:0] d;
        wr(A_REG, 8'h05, 1'b1);           // gf0 + idle with done
        chk("R5 same-cycle halt", {7'd0, halt}, 8'h01);
        pulse_irq();
        rd(A_REG, d);
        chk("R6 after same-cycle", d, 8'h04);
    endtask

    task automatic t_stop();
        logic [7:0] d;
        wr(A_REG, 8'h82, 1'b0);
        pulse_done();
        chk("R7 stop halt", {7'd0, halt}, 8'h01);
        pulse_irq(); cyc();
        chk("R7 irq ignored", {7'd0, halt}, 8'h01);
        rd(A_REG, d);
        chk("R7 stop bit kept", d, 8'h82);
        pulse_wdog();
        chk("R9 halt cleared", {7'd0, halt}, 8'h00);
        rd(A_REG, d);
        chk("R9 reg cleared", d, 8'h00);
    endtask

    task automatic t_both();
        logic [7:0] d;
        wr(A_REG, 8'h03, 1'b1);
        chk("R8 halt", {7'd0, halt}, 8'h01);
        pulse_irq(); cyc();
        chk("R8 stop wins", {7'd0, halt}, 8'h01);
        rd(A_REG, d);
        chk("R8 bits kept", d, 8'h03);
        pulse_wdog();
    endtask

    task automatic t_cancel();
        logic [7:0] d;
        wr(A_REG, 8'h01, 1'b0);
        wr(A_REG, 8'h08, 1'b0);
        pulse_done(); cyc();
        chk("R11 cancelled", {7'd0, halt}, 8'h00);
        rd(A_REG, d);
        chk("R11 reg", d, 8'h08);
    endtask

    task automatic t_race();
        logic [7:0] d;
        wr(A_REG, 8'h8D, 1'b1);
        chk("R9 race setup", {7'd0, halt}, 8'h01);
        irq_wake = 1'b1; wdog_rst = 1'b1;
        cyc();
        irq_wake = 1'b0; wdog_rst = 1'b0;
        rd(A_REG, d);
        chk("R9 wdog beats irq", d, 8'h00);
        chk("R9 race halt", {7'd0, halt}, 8'h00);
    endtask

    initial begin
        sfr_addr = A_REG;
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        t_reset();
        t_regs();
        t_idle_deferred();
        t_same_cycle();
        t_stop();
        t_both();
        t_cancel();
        t_race();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
            $finish;
        end
    end
endmodule